// File: doc/BRIEF.md
# Outbound Descriptor-Chain DMA Engine

This block moves bytes from memory to a peripheral by walking a linked list of data descriptors. Each descriptor has four 32-bit words: a link to the next descriptor, the first byte address of its buffer, a control word, and the address one past the last byte. The engine reads the buffer one aligned word at a time over a request/grant read port. It splits each word into bytes and hands them to a client over a valid/ready byte stream. Backpressure stalls the stream and loses no bytes.

When the last byte of a buffer has been accepted, the engine does four things in order. It pulses a raw interrupt bit if the descriptor asks for one. It writes the descriptor back to memory. It then either follows the link or, at end of list, marks the parent context descriptor as disabled and halts. The current descriptor address and a buffer pointer are exposed for the register block next to it. The buffer pointer moves in steps of a programmable chunk size. Interrupt masking and register access belong to neighbouring logic.

Top module: `dmao_engine`

## Requirements
- R1: While `rst` is high, `m_valid`, `rd_req`, `wr_req`, `running`, `eol_flag` and every bit of `irq_raw_set` are 0.
- R2: A `start` pulse in the idle state does four things. It captures `start_desc` and `start_ctx`. It clears `eol_flag` and raises `running` on the following cycle. It fetches the descriptor words at offsets 0 (link), 4 (buffer start), 8 (control) and 12 (buffer end). A `start` pulse while `running` is 1 has no effect.
- R3: The bytes from buffer start up to buffer end minus one leave on `m_data` in ascending address order. The byte at address a is taken from bits 8*(a mod 4)+7 down to 8*(a mod 4) of the aligned word. Once `m_valid` is 1 it holds, with `m_data` and `m_last`, until `m_ready` accepts the beat.
- R4: When control bit 3 (packet end) is set, `m_last` is 1 on the final byte of that descriptor only. When bit 3 is clear, `m_last` stays 0 for the whole descriptor.
- R5: `buf_ptr` is loaded with the buffer start when a descriptor is taken up. It advances by `CHUNK_BYTES` each time that many bytes of the descriptor have been accepted. It is set to the buffer end on the cycle after the final byte is accepted.
- R6: A descriptor whose buffer start is not below its buffer end streams no byte and is otherwise completed like any other.
- R7: Control bit 4 (interrupt) gives a one-cycle pulse on `irq_raw_set` bit 2 once the descriptor is finished. No other bit of `irq_raw_set` is ever set.
- R8: The four words of a finished descriptor are written back unchanged to their own addresses before any further read. Control bit 5, bit 11 and bits 31:16 have no effect on the transfer.
- R9: When control bit 0 (end of list) is clear, `desc_ptr` takes the link word and the next descriptor is fetched from that address.
- R10: When control bit 0 is set, the engine reads the context word at `start_ctx`+4 and writes it back with bit 15 set and every other bit unchanged. It then raises `eol_flag` and drops `running`.
- R11: `rd_req` and `wr_req` are never both 1. A request holds its address (and write data) stable until it is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, honoured when idle |
| start_desc | input | 32 | Address of the first data descriptor |
| start_ctx | input | 32 | Address of the parent context descriptor |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 32 | Word-aligned read address |
| rd_gnt | input | 1 | Read request accepted |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | 32 | Read data |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| wr_gnt | input | 1 | Write accepted |
| m_valid | output | 1 | Stream byte valid |
| m_ready | input | 1 | Stream consumer ready |
| m_data | output | 8 | Stream byte |
| m_last | output | 1 | Final byte of a packet |
| desc_ptr | output | 32 | Address of the current data descriptor |
| buf_ptr | output | 32 | Buffer progress pointer |
| irq_raw_set | output | IRQ_W | One-cycle raw interrupt set pulses |
| eol_flag | output | 1 | End of list reached |
| running | output | 1 | Engine busy |

## Verification
Three descriptor shapes are run. The first has an unaligned start whose bytes cross two chunk boundaries and end inside a word. This separates lane selection, partial-word counts and pointer stepping. The second has a zero-length buffer, which tests that completion without data still pulses and writes back. The third is aligned and ends the list, so packet-end and no-packet-end marking can be told apart, as can chaining and stopping. Stream readiness and memory grants follow irregular patterns, with a second chain under slower readiness. A start pulse sent mid-run shows whether a busy engine ignores new starts.

// File: rtl/dmao_pkg.sv
package dmao_pkg;
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int DESC_WORDS = 4;

  // descriptor word slots (memory order, decoded by software)
  localparam int DW_LINK  = 0;
  localparam int DW_START = 1;
  localparam int DW_CTRL  = 2;
  localparam int DW_STOP  = 3;

  // control word bits
  localparam int CB_EOL  = 0;
  localparam int CB_PEND = 3;
  localparam int CB_IRQ  = 4;

  // parent context: control word slot and its disable bit
  localparam int CTX_CTRL_SLOT = 1;
  localparam int CTX_DIS_BIT   = 15;

  // raw interrupt bit for a finished data descriptor
  localparam int IRQ_DATA_BIT = 2;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FETCH_REQ,
    S_FETCH_WAIT,
    S_SETUP,
    S_DATA_REQ,
    S_DATA_WAIT,
    S_PUSH,
    S_DRAIN,
    S_DONE,
    S_WB,
    S_CTX_REQ,
    S_CTX_WAIT,
    S_CTX_WR
  } walk_state_e;
endpackage

// File: rtl/dmao_unpack.sv
module dmao_unpack #(
  parameter int WORD_BYTES = 4,
  localparam int LANE_W = $clog2(WORD_BYTES),
  localparam int CNT_W  = $clog2(WORD_BYTES + 1),
  localparam int WW     = 8 * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [WW-1:0]     ld_word,
  input  logic [LANE_W-1:0] ld_lane,
  input  logic [CNT_W-1:0]  ld_count,
  input  logic              ld_final,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_final,
  output logic              empty
);
  logic [WW-1:0]    sh_q;
  logic [CNT_W-1:0] rem_q;
  logic             fin_q;

  // a new word may enter as the last byte of the previous one leaves
  assign ld_ready  = (rem_q == '0) || ((rem_q == CNT_W'(1)) && out_ready);
  assign out_valid = (rem_q != '0);
  assign out_data  = sh_q[7:0];
  assign out_final = fin_q && (rem_q == CNT_W'(1));
  assign empty     = (rem_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      rem_q <= '0;
      fin_q <= 1'b0;
    end else if (ld_valid && ld_ready) begin
      sh_q  <= ld_word >> {ld_lane, 3'b000};
      rem_q <= ld_count;
      fin_q <= ld_final;
    end else if (out_valid && out_ready) begin
      sh_q  <= sh_q >> 8;
      rem_q <= rem_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/dmao_walk.sv
module dmao_walk
  import dmao_pkg::*;
#(
  parameter int CHUNK_BYTES = 2048,
  parameter int IRQ_W       = 4,
  localparam int LANE_W  = $clog2(WORD_BYTES),
  localparam int CNT_W   = $clog2(WORD_BYTES + 1),
  localparam int CHUNK_W = $clog2(CHUNK_BYTES + 1),
  localparam int IDX_W   = $clog2(DESC_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  word_t             start_desc,
  input  word_t             start_ctx,
  output logic              rd_req,
  output word_t             rd_addr,
  input  logic              rd_gnt,
  input  logic              rd_rvalid,
  input  word_t             rd_rdata,
  output logic              wr_req,
  output word_t             wr_addr,
  output word_t             wr_data,
  input  logic              wr_gnt,
  output logic              ld_valid,
  input  logic              ld_ready,
  output word_t             ld_word,
  output logic [LANE_W-1:0] ld_lane,
  output logic [CNT_W-1:0]  ld_count,
  output logic              ld_final,
  input  logic              unpack_empty,
  input  logic              beat_fire,
  input  logic              beat_final,
  output logic              pkt_end,
  output word_t             desc_ptr,
  output word_t             buf_ptr,
  output logic [IRQ_W-1:0]  irq_raw_set,
  output logic              eol_flag,
  output logic              running
);
  walk_state_e                  state_q;
  logic [IDX_W-1:0]             widx_q;
  word_t [DESC_WORDS-1:0]       desc_q;
  word_t                        desc_ptr_q;
  word_t                        ctx_ptr_q;
  word_t                        rd_ptr_q;
  word_t                        buf_ptr_q;
  word_t                        word_q;
  word_t                        ctx_word_q;
  logic [CHUNK_W-1:0]           chunk_q;
  logic                         eol_q;
  logic [IRQ_W-1:0]             irq_q;

  logic [LANE_W-1:0] lane;
  logic [CNT_W-1:0]  room;
  word_t             left;
  logic              push_final;
  logic [CNT_W-1:0]  push_count;
  word_t             ctx_addr;
  word_t             slot_addr;

  always_comb begin
    lane       = rd_ptr_q[LANE_W-1:0];
    room       = CNT_W'(WORD_BYTES) - CNT_W'(lane);
    left       = desc_q[DW_STOP] - rd_ptr_q;
    push_final = (left <= word_t'(room));
    push_count = push_final ? CNT_W'(left) : room;
    ctx_addr   = ctx_ptr_q + word_t'(CTX_CTRL_SLOT * WORD_BYTES);
    slot_addr  = desc_ptr_q + (word_t'(widx_q) << LANE_W);
  end

  // memory ports decoded from the state register
  always_comb begin
    rd_req  = 1'b0;
    rd_addr = '0;
    wr_req  = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    case (state_q)
      S_FETCH_REQ: begin
        rd_req  = 1'b1;
        rd_addr = slot_addr;
      end
      S_DATA_REQ: begin
        rd_req  = 1'b1;
        rd_addr = {rd_ptr_q[WORD_W-1:LANE_W], {LANE_W{1'b0}}};
      end
      S_CTX_REQ: begin
        rd_req  = 1'b1;
        rd_addr = ctx_addr;
      end
      S_WB: begin
        wr_req  = 1'b1;
        wr_addr = slot_addr;
        wr_data = desc_q[widx_q];
      end
      S_CTX_WR: begin
        wr_req  = 1'b1;
        wr_addr = ctx_addr;
        wr_data = ctx_word_q | (word_t'(1) << CTX_DIS_BIT);
      end
      default: ;
    endcase
  end

  assign ld_valid    = (state_q == S_PUSH);
  assign ld_word     = word_q;
  assign ld_lane     = lane;
  assign ld_count    = push_count;
  assign ld_final    = push_final;
  assign pkt_end     = desc_q[DW_CTRL][CB_PEND];
  assign desc_ptr    = desc_ptr_q;
  assign buf_ptr     = buf_ptr_q;
  assign irq_raw_set = irq_q;
  assign eol_flag    = eol_q;
  assign running     = (state_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      widx_q     <= '0;
      desc_q     <= '0;
      desc_ptr_q <= '0;
      ctx_ptr_q  <= '0;
      rd_ptr_q   <= '0;
      buf_ptr_q  <= '0;
      word_q     <= '0;
      ctx_word_q <= '0;
      chunk_q    <= '0;
      eol_q      <= 1'b0;
      irq_q      <= '0;
    end else begin
      irq_q <= '0;

      // progress pointer follows accepted bytes, one chunk at a time
      if (beat_fire) begin
        if (beat_final || (chunk_q == CHUNK_W'(CHUNK_BYTES - 1))) begin
          buf_ptr_q <= buf_ptr_q + word_t'(chunk_q) + word_t'(1);
          chunk_q   <= '0;
        end else begin
          chunk_q <= chunk_q + CHUNK_W'(1);
        end
      end

      case (state_q)
        S_IDLE: begin
          if (start) begin
            desc_ptr_q <= start_desc;
            ctx_ptr_q  <= start_ctx;
            eol_q      <= 1'b0;
            widx_q     <= '0;
            state_q    <= S_FETCH_REQ;
          end
        end
        S_FETCH_REQ: begin
          if (rd_gnt) state_q <= S_FETCH_WAIT;
        end
        S_FETCH_WAIT: begin
          if (rd_rvalid) begin
            desc_q[widx_q] <= rd_rdata;
            if (widx_q == IDX_W'(DESC_WORDS - 1)) begin
              state_q <= S_SETUP;
            end else begin
              widx_q  <= widx_q + IDX_W'(1);
              state_q <= S_FETCH_REQ;
            end
          end
        end
        S_SETUP: begin
          buf_ptr_q <= desc_q[DW_START];
          rd_ptr_q  <= desc_q[DW_START];
          chunk_q   <= '0;
          state_q   <= (desc_q[DW_START] < desc_q[DW_STOP]) ? S_DATA_REQ : S_DONE;
        end
        S_DATA_REQ: begin
          if (rd_gnt) state_q <= S_DATA_WAIT;
        end
        S_DATA_WAIT: begin
          if (rd_rvalid) begin
            word_q  <= rd_rdata;
            state_q <= S_PUSH;
          end
        end
        S_PUSH: begin
          if (ld_ready) begin
            rd_ptr_q <= rd_ptr_q + word_t'(push_count);
            state_q  <= push_final ? S_DRAIN : S_DATA_REQ;
          end
        end
        S_DRAIN: begin
          if (unpack_empty) state_q <= S_DONE;
        end
        S_DONE: begin
          irq_q[IRQ_DATA_BIT] <= desc_q[DW_CTRL][CB_IRQ];
          widx_q              <= '0;
          state_q             <= S_WB;
        end
        S_WB: begin
          if (wr_gnt) begin
            if (widx_q == IDX_W'(DESC_WORDS - 1)) begin
              widx_q <= '0;
              if (desc_q[DW_CTRL][CB_EOL]) begin
                state_q <= S_CTX_REQ;
              end else begin
                desc_ptr_q <= desc_q[DW_LINK];
                state_q    <= S_FETCH_REQ;
              end
            end else begin
              widx_q <= widx_q + IDX_W'(1);
            end
          end
        end
        S_CTX_REQ: begin
          if (rd_gnt) state_q <= S_CTX_WAIT;
        end
        S_CTX_WAIT: begin
          if (rd_rvalid) begin
            ctx_word_q <= rd_rdata;
            state_q    <= S_CTX_WR;
          end
        end
        S_CTX_WR: begin
          if (wr_gnt) begin
            eol_q   <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmao_engine.sv
module dmao_engine
  import dmao_pkg::*;
#(
  parameter int CHUNK_BYTES = 2048,
  parameter int IRQ_W       = 4,
  localparam int LANE_W = $clog2(WORD_BYTES),
  localparam int CNT_W  = $clog2(WORD_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       start_desc,
  input  logic [31:0]       start_ctx,
  output logic              rd_req,
  output logic [31:0]       rd_addr,
  input  logic              rd_gnt,
  input  logic              rd_rvalid,
  input  logic [31:0]       rd_rdata,
  output logic              wr_req,
  output logic [31:0]       wr_addr,
  output logic [31:0]       wr_data,
  input  logic              wr_gnt,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [7:0]        m_data,
  output logic              m_last,
  output logic [31:0]       desc_ptr,
  output logic [31:0]       buf_ptr,
  output logic [IRQ_W-1:0]  irq_raw_set,
  output logic              eol_flag,
  output logic              running
);
  logic              ld_valid;
  logic              ld_ready;
  word_t             ld_word;
  logic [LANE_W-1:0] ld_lane;
  logic [CNT_W-1:0]  ld_count;
  logic              ld_final;
  logic              unpack_empty;
  logic              beat_final;
  logic              pkt_end;
  logic              beat_fire;

  assign beat_fire = m_valid && m_ready;
  assign m_last    = beat_final && pkt_end;

  dmao_walk #(
    .CHUNK_BYTES(CHUNK_BYTES),
    .IRQ_W      (IRQ_W)
  ) u_walk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .start_desc  (start_desc),
    .start_ctx   (start_ctx),
    .rd_req      (rd_req),
    .rd_addr     (rd_addr),
    .rd_gnt      (rd_gnt),
    .rd_rvalid   (rd_rvalid),
    .rd_rdata    (rd_rdata),
    .wr_req      (wr_req),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_gnt      (wr_gnt),
    .ld_valid    (ld_valid),
    .ld_ready    (ld_ready),
    .ld_word     (ld_word),
    .ld_lane     (ld_lane),
    .ld_count    (ld_count),
    .ld_final    (ld_final),
    .unpack_empty(unpack_empty),
    .beat_fire   (beat_fire),
    .beat_final  (beat_final),
    .pkt_end     (pkt_end),
    .desc_ptr    (desc_ptr),
    .buf_ptr     (buf_ptr),
    .irq_raw_set (irq_raw_set),
    .eol_flag    (eol_flag),
    .running     (running)
  );

  dmao_unpack #(
    .WORD_BYTES(WORD_BYTES)
  ) u_unpack (
    .clk      (clk),
    .rst      (rst),
    .ld_valid (ld_valid),
    .ld_ready (ld_ready),
    .ld_word  (ld_word),
    .ld_lane  (ld_lane),
    .ld_count (ld_count),
    .ld_final (ld_final),
    .out_valid(m_valid),
    .out_ready(m_ready),
    .out_data (m_data),
    .out_final(beat_final),
    .empty    (unpack_empty)
  );
endmodule

// File: rtl/dmao_checks.sv
module dmao_checks
  import dmao_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             rd_req,
  input logic [31:0]      rd_addr,
  input logic             rd_gnt,
  input logic             wr_req,
  input logic [31:0]      wr_addr,
  input logic [31:0]      wr_data,
  input logic             wr_gnt,
  input logic             m_valid,
  input logic             m_ready,
  input logic [7:0]       m_data,
  input logic             m_last,
  input logic [IRQ_W-1:0] irq_raw_set,
  input logic             eol_flag,
  input logic             running
);
  localparam logic [IRQ_W-1:0] IRQ_OK = IRQ_W'(1) << IRQ_DATA_BIT;

  a_r3_beat_held: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  a_r3_valid_only_busy: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> running);

  a_r4_last_on_beat: assert property (@(posedge clk) disable iff (rst)
    m_last |-> m_valid);

  a_r11_rd_held: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_gnt) |=> (rd_req && $stable(rd_addr)));

  a_r11_wr_held: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_gnt) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  a_r11_one_port: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req));

  a_r7_irq_bit: assert property (@(posedge clk) disable iff (rst)
    (irq_raw_set & ~IRQ_OK) == '0);

  a_r10_halt_on_eol: assert property (@(posedge clk) disable iff (rst)
    $rose(eol_flag) |-> !running);

  a_r2_start_idle: assert property (@(posedge clk) disable iff (rst)
    (start && !running) |=> (running && !eol_flag));
endmodule

bind dmao_engine dmao_checks #(.IRQ_W(IRQ_W)) u_checks (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .rd_req     (rd_req),
  .rd_addr    (rd_addr),
  .rd_gnt     (rd_gnt),
  .wr_req     (wr_req),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .wr_gnt     (wr_gnt),
  .m_valid    (m_valid),
  .m_ready    (m_ready),
  .m_data     (m_data),
  .m_last     (m_last),
  .irq_raw_set(irq_raw_set),
  .eol_flag   (eol_flag),
  .running    (running)
);

// File: tb/tb_dmao_engine.sv
module tb_dmao_engine;
  localparam int CHUNK = 8;
  localparam int IRQ_W = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [31:0]       start_desc = '0;
  logic [31:0]       start_ctx = '0;
  logic              rd_req;
  logic [31:0]       rd_addr;
  logic              rd_gnt = 1'b0;
  logic              rd_rvalid = 1'b0;
  logic [31:0]       rd_rdata = '0;
  logic              wr_req;
  logic [31:0]       wr_addr;
  logic [31:0]       wr_data;
  logic              wr_gnt = 1'b0;
  logic              m_valid;
  logic              m_ready = 1'b0;
  logic [7:0]        m_data;
  logic              m_last;
  logic [31:0]       desc_ptr;
  logic [31:0]       buf_ptr;
  logic [IRQ_W-1:0]  irq_raw_set;
  logic              eol_flag;
  logic              running;

  always #10 clk = ~clk;

  dmao_engine #(.CHUNK_BYTES(CHUNK), .IRQ_W(IRQ_W)) dut (
    .clk(clk), .rst(rst), .start(start), .start_desc(start_desc),
    .start_ctx(start_ctx), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_gnt(rd_gnt), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_gnt(wr_gnt),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .desc_ptr(desc_ptr), .buf_ptr(buf_ptr), .irq_raw_set(irq_raw_set),
    .eol_flag(eol_flag), .running(running)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  // memory model: 256 words, irregular grants, read latency of two
  logic [31:0] mem [0:255];
  int          wr_hits [0:255];
  logic [31:0] dv [0:15];
  bit          overlap_seen = 0;

  initial begin
    int unsigned cyc = 0;
    int lat = 0;
    bit busy = 0;
    logic [31:0] raddr = '0;
    logic [31:0] rcap = '0;
    logic [31:0] wa = '0;
    logic [31:0] wd = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst) begin
        rd_gnt = 0; rd_rvalid = 0; wr_gnt = 0; busy = 0; lat = 0;
        continue;
      end
      rd_rvalid = 0;
      if (busy) begin
        lat--;
        if (lat == 0) begin
          rd_rvalid = 1;
          rd_rdata  = mem[raddr[9:2]];
          busy      = 0;
        end
      end
      if (rd_gnt) begin
        busy = 1; lat = 2; raddr = rcap;
      end
      rd_gnt = rd_req && !busy && ((cyc % 3) != 0);
      rcap   = rd_addr;
      if (wr_gnt) begin
        mem[wa[9:2]] = wd;
        wr_hits[wa[9:2]]++;
      end
      wr_gnt = wr_req && ((cyc % 2) == 0);
      wa = wr_addr;
      wd = wr_data;
      if (rd_req && wr_req) overlap_seen = 1;
    end
  end

  // scoreboard
  typedef struct {
    logic [7:0]  d;
    logic        last;
    logic [31:0] ptr;
  } exp_t;
  exp_t q[$];
  int   ready_mode = 0;
  int   irq_cnt = 0;
  int   irq_bad = 0;

  task automatic put_desc(input logic [31:0] at, input logic [31:0] nxt,
                          input logic [31:0] st, input logic [31:0] sp,
                          input logic [31:0] ctl);
    mem[at[9:2]]     = nxt;
    mem[at[9:2] + 1] = st;
    mem[at[9:2] + 2] = ctl;
    mem[at[9:2] + 3] = sp;
    dv[at[5:2]]      = nxt;
    dv[at[5:2] + 1]  = st;
    dv[at[5:2] + 2]  = ctl;
    dv[at[5:2] + 3]  = sp;
    for (int a = int'(st); a < int'(sp); a++) begin
      exp_t e;
      bit fin;
      fin    = (a == int'(sp) - 1);
      e.d    = bval(a);
      e.last = fin && ctl[3];
      e.ptr  = fin ? sp : st + 32'(CHUNK * ((a - int'(st) + 1) / CHUNK));
      q.push_back(e);
    end
  endtask

  // monitor: decides ready, compares each beat that will fire
  initial begin
    int unsigned cyc = 0;
    bit pend = 0;
    logic [31:0] pend_ptr = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst) begin
        m_ready = 0;
        continue;
      end
      if (pend) begin
        pend = 0;
        chk(buf_ptr == pend_ptr, "R5 buf_ptr after beat", buf_ptr, pend_ptr);
      end
      if (irq_raw_set[2]) irq_cnt++;
      if ((irq_raw_set & 4'b1011) != 0) irq_bad++;
      m_ready = (ready_mode == 0) ? ((cyc % 4) != 1) : ((cyc % 3) == 0);
      if (m_valid && m_ready) begin
        if (q.size() == 0) begin
          chk(0, "R3 unexpected beat", {24'd0, m_data}, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(m_data == e.d, "R3 byte", {24'd0, m_data}, {24'd0, e.d});
          chk(m_last == e.last, "R4 last", {31'd0, m_last}, {31'd0, e.last});
          pend = 1;
          pend_ptr = e.ptr;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R3 watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic go(input logic [31:0] d, input logic [31:0] c);
    @(negedge clk);
    start = 1; start_desc = d; start_ctx = c;
    @(negedge clk);
    start = 0;
    chk(eol_flag == 0, "R2 eol cleared by start", {31'd0, eol_flag}, 32'd0);
    chk(running == 1, "R2 running after start", {31'd0, running}, 32'd1);
  endtask

  task automatic wait_idle();
    while (running) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = {bval(4*i+3), bval(4*i+2), bval(4*i+1), bval(4*i)};
      wr_hits[i] = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(m_valid == 0 && rd_req == 0 && wr_req == 0, "R1 ports idle in reset",
        {29'd0, m_valid, rd_req, wr_req}, 32'd0);
    chk(running == 0 && eol_flag == 0 && irq_raw_set == 0, "R1 status in reset",
        {26'd0, irq_raw_set, running, eol_flag}, 32'd0);
    rst = 0;

    // chain 1: unaligned 19 bytes with packet end and irq (ignored bits set),
    // empty buffer with irq, aligned 12 bytes ending the list
    put_desc(32'h000, 32'h010, 32'h203, 32'h216, 32'hBEEF_0838);
    put_desc(32'h010, 32'h020, 32'h240, 32'h240, 32'h0000_0010);
    put_desc(32'h020, 32'h999, 32'h250, 32'h25C, 32'h0000_0001);
    mem[253] = 32'h5A5A_0021;
    ready_mode = 0;
    irq_cnt = 0;
    go(32'h000, 32'h3F0);
    repeat (6) @(negedge clk);
    start = 1; start_desc = 32'h030; start_ctx = 32'h3E0;  // R2 busy start
    @(negedge clk);
    start = 0;
    wait_idle();
    chk(q.size() == 0, "R3 all bytes of chain delivered", q.size(), 0);
    chk(irq_cnt == 2, "R7 irq pulses chain 1", irq_cnt, 2);
    chk(irq_bad == 0, "R7 only bit 2 pulsed", irq_bad, 0);
    chk(eol_flag == 1 && running == 0, "R10 halted at end of list",
        {30'd0, eol_flag, running}, 32'h2);
    chk(mem[253] == 32'h5A5A_8021, "R10 context disable bit", mem[253], 32'h5A5A_8021);
    chk(wr_hits[253] == 1, "R10 one context write", wr_hits[253], 1);
    chk(desc_ptr == 32'h020, "R9 followed links", desc_ptr, 32'h020);
    chk(buf_ptr == 32'h25C, "R5 final buf_ptr", buf_ptr, 32'h25C);
    for (int w = 0; w < 12; w++) begin
      chk(wr_hits[w] == 1 && mem[w] == dv[w], "R8 descriptor written back unchanged",
          mem[w], dv[w]);
    end
    chk(wr_hits[4] == 1, "R6 empty descriptor completed", wr_hits[4], 1);
    chk(wr_hits[12] == 0 && wr_hits[248] == 0, "R2 busy start ignored",
        wr_hits[12], 0);
    chk(!overlap_seen, "R11 read and write never together", {31'd0, overlap_seen}, 0);

    // chain 2: single 6-byte descriptor, eol+packet end+irq, slow consumer
    put_desc(32'h030, 32'h000, 32'h301, 32'h307, 32'h0000_0019);
    mem[249] = 32'h0000_7F00;
    ready_mode = 1;
    irq_cnt = 0;
    go(32'h030, 32'h3E0);
    wait_idle();
    chk(q.size() == 0, "R3 all bytes of chain 2", q.size(), 0);
    chk(irq_cnt == 1, "R7 irq pulse chain 2", irq_cnt, 1);
    chk(mem[249] == 32'h0000_FF00, "R10 context word chain 2", mem[249], 32'h0000_FF00);
    chk(eol_flag == 1, "R10 eol flag chain 2", {31'd0, eol_flag}, 1);
    chk(buf_ptr == 32'h307, "R5 buf_ptr chain 2", buf_ptr, 32'h307);
    for (int w = 12; w < 16; w++) begin
      chk(wr_hits[w] == 1 && mem[w] == dv[w], "R8 chain 2 write back", mem[w], dv[w]);
    end
    chk(!overlap_seen, "R11 no overlap chain 2", {31'd0, overlap_seen}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule